// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate with Prefix-Tree Accumulator

This block multiplies two unsigned 32-bit operands and folds the full 64-bit product into a stored running total. On every clock edge where the input strobe is high, the product is captured in an output register. In that same edge the accumulator takes the sum of its previous value and the new product. The accumulation adder is a parallel-prefix tree of the sparse, two-sweep kind. It forms per-bit generate and propagate terms. It then builds group carries in an up-sweep followed by a down-sweep, about 2·log2(N)−1 levels deep. Each sum bit is the propagate term XOR the carry into that bit.

A synchronous clear zeroes the total. When a clear arrives together with a strobed operand pair, the total restarts from that product alone. The total wraps modulo 2^64. The carry out of the most recent accumulating add is kept as a flag beside it. The block suits filter taps, dot products and similar streaming sums in which the host restarts the sum at frame boundaries.

Top module: `mac_bk_acc`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `prod_q`, `acc_q` and `acc_carry` are all zero.
- R2: On a clock edge where `in_valid` is 1, `prod_q` takes the full 64-bit unsigned product `op_a * op_b`. For example, all-ones operands give 0xFFFFFFFE00000001.
- R3: On a clock edge where `in_valid` is 1 and `clr` is 0, `acc_q` becomes (previous `acc_q` + product) modulo 2^64.
- R4: On the same edge as R3, `acc_carry` takes the carry out of bit 63 of that addition. It is 1 exactly when the total wrapped.
- R5: On a clock edge where `clr` is 1 and `in_valid` is 0, `acc_q` and `acc_carry` become 0, and `prod_q` keeps its value.
- R6: On a clock edge where `clr` and `in_valid` are both 1, `acc_q` becomes the product alone and `acc_carry` becomes 0.
- R7: On a clock edge where both `in_valid` and `clr` are 0, `prod_q`, `acc_q` and `acc_carry` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair strobe |
| clr | input | 1 | Synchronous clear of the running total |
| op_a | input | 32 | Multiplicand, unsigned |
| op_b | input | 32 | Multiplier, unsigned |
| prod_q | output | 64 | Registered product of the last strobed pair |
| acc_q | output | 64 | Running total modulo 2^64 |
| acc_carry | output | 1 | Carry out of the last accumulating add |

## Verification
Two functions can fall on the same edge: clearing the total and accumulating a new product. When both happen, the product must seed the total, and the old total must not be added in. The bench provokes this by raising `clr` together with `in_valid`. It does so in directed steps, both right after large wrapping totals and at random points in a long random stream. A behavioural model predicts every edge: it keeps its own 64-bit total and carry, and it seeds rather than adds when both strobes are set. The model is compared with all three outputs on every clock. The comparison checks that no trace of the previous total survives the combined event. It also checks that the carry flag drops to zero even when the previous add had set it.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Group generate / propagate pair used by the prefix tree
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a more significant group (hi) with the adjacent lower group (lo)
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Unsigned shift-and-add product, one partial product per multiplier bit
  function automatic logic [63:0] pp_product(logic [31:0] a, logic [31:0] b);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++) begin
      if (b[i]) acc = acc + (64'(a) << i);
    end
    return acc;
  endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [2*OP_W-1:0] prod
);
  localparam int PW = 2 * OP_W;

  // Partial-product array, summed row by row
  logic [PW-1:0] rows [OP_W];

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    assign rows[i] = b[i] ? (PW'(a) << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < OP_W; i++) prod = prod + rows[i];
  end

endmodule

// File: rtl/mac_bk_adder.sv
module mac_bk_adder
  import mac_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LOG = $clog2(W);
  localparam int STG = 2 * LOG - 1;

  // node[s][i]: group term ending at bit i after stage s
  gp_t node [STG+1][W];
  logic [W:0] carry;

  // Per-bit generate and propagate
  for (genvar i = 0; i < W; i++) begin : g_pre
    assign node[0][i] = '{g: a[i] & b[i], p: a[i] ^ b[i]};
  end

  // Up-sweep: distance doubles each level, only at aligned positions
  for (genvar l = 0; l < LOG; l++) begin : g_up
    localparam int D = 2 ** l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i + 1) % (2 * D)) == 0) begin : g_node
        assign node[l+1][i] = gp_merge(node[l][i], node[l][i-D]);
      end else begin : g_pass
        assign node[l+1][i] = node[l][i];
      end
    end
  end

  // Down-sweep: fill the remaining positions, halving the distance
  for (genvar k = 0; k < LOG - 1; k++) begin : g_dn
    localparam int D = 2 ** (LOG - 2 - k);
    localparam int S = LOG + k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if ((((i + 1) % (2 * D)) == D) && (i >= 2 * D)) begin : g_node
        assign node[S+1][i] = gp_merge(node[S][i], node[S][i-D]);
      end else begin : g_pass
        assign node[S+1][i] = node[S][i];
      end
    end
  end

  // Sum phase
  assign carry[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_sum
    assign carry[i+1] = node[STG][i].g;
    assign sum[i]     = node[0][i].p ^ carry[i];
  end
  assign cout = carry[W];

endmodule

// File: rtl/mac_bk_acc.sv
module mac_bk_acc #(
  parameter int OP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                clr,
  input  logic [OP_W-1:0]     op_a,
  input  logic [OP_W-1:0]     op_b,
  output logic [2*OP_W-1:0]   prod_q,
  output logic [2*OP_W-1:0]   acc_q,
  output logic                acc_carry
);
  localparam int ACC_W = 2 * OP_W;

  logic [ACC_W-1:0] prod_now;
  logic [ACC_W-1:0] sum_now;
  logic             cout_now;

  // Named events for the checker
  logic evt_accum;
  logic evt_seed;
  logic evt_zero;
  logic evt_wrap;

  mac_mult #(.OP_W(OP_W)) u_mult (
    .a    (op_a),
    .b    (op_b),
    .prod (prod_now)
  );

  mac_bk_adder #(.W(ACC_W)) u_add (
    .a    (acc_q),
    .b    (prod_now),
    .sum  (sum_now),
    .cout (cout_now)
  );

  assign evt_accum = in_valid & ~clr;
  assign evt_seed  = in_valid & clr;
  assign evt_zero  = clr & ~in_valid;
  assign evt_wrap  = evt_accum & cout_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q    <= '0;
      acc_q     <= '0;
      acc_carry <= 1'b0;
    end else begin
      if (in_valid) prod_q <= prod_now;
      if (evt_accum) begin
        acc_q     <= sum_now;
        acc_carry <= cout_now;
      end else if (evt_seed) begin
        acc_q     <= prod_now;
        acc_carry <= 1'b0;
      end else if (evt_zero) begin
        acc_q     <= '0;
        acc_carry <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mac_bk_acc_chk.sv
module mac_bk_acc_chk #(
  parameter int OP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              clr,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [2*OP_W-1:0] prod_q,
  input logic [2*OP_W-1:0] acc_q,
  input logic              acc_carry,
  input logic              evt_wrap
);
  localparam int ACC_W = 2 * OP_W;

  logic [ACC_W-1:0] want_prod;
  assign want_prod = ACC_W'(op_a) * ACC_W'(op_b);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (prod_q == '0 && acc_q == '0 && !acc_carry));

  assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prod_q == $past(want_prod));

  assert_accumulate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=>
      {acc_carry, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(want_prod)}));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wrap |=> acc_carry);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (acc_q == '0 && !acc_carry && $stable(prod_q)));

  assert_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_valid) |=> (acc_q == $past(want_prod) && !acc_carry));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_valid) |=> ($stable(acc_q) && $stable(prod_q) && $stable(acc_carry)));

endmodule

bind mac_bk_acc mac_bk_acc_chk #(.OP_W(OP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .clr       (clr),
  .op_a      (op_a),
  .op_b      (op_b),
  .prod_q    (prod_q),
  .acc_q     (acc_q),
  .acc_carry (acc_carry),
  .evt_wrap  (evt_wrap)
);

// File: tb/mac_bk_acc_tb.sv
module mac_bk_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        clr = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [63:0] prod_q;
  logic [63:0] acc_q;
  logic        acc_carry;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state
  logic [63:0] m_prod = '0;
  logic [63:0] m_acc = '0;
  logic        m_c = 1'b0;
  int          wraps_seen = 0;

  always #4 clk = ~clk;

  mac_bk_acc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .clr       (clr),
    .op_a      (op_a),
    .op_b      (op_b),
    .prod_q    (prod_q),
    .acc_q     (acc_q),
    .acc_carry (acc_carry)
  );

  task automatic check64(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare
  task automatic step(bit v, bit c, logic [31:0] a, logic [31:0] b);
    logic [64:0] s;
    logic [63:0] p;
    string rp, ra;
    in_valid = v; clr = c; op_a = a; op_b = b;
    @(posedge clk);
    p = 64'(a) * 64'(b);
    if (v && !c) begin
      s = {1'b0, m_acc} + {1'b0, p};
      m_acc = s[63:0]; m_c = s[64]; m_prod = p;
      if (s[64]) wraps_seen++;
      rp = "R2"; ra = "R3/R4";
    end else if (v && c) begin
      m_acc = p; m_c = 1'b0; m_prod = p;
      rp = "R2"; ra = "R6";
    end else if (c) begin
      m_acc = '0; m_c = 1'b0;
      rp = "R5"; ra = "R5";
    end else begin
      rp = "R7"; ra = "R7";
    end
    @(negedge clk);
    check64(rp, "prod_q", prod_q, m_prod);
    check64(ra, "acc_q", acc_q, m_acc);
    check64(ra, "acc_carry", 64'(acc_carry), 64'(m_c));
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: outputs are zero while reset is held, even with strobes active
    in_valid = 1'b1; op_a = 32'd7; op_b = 32'd9;
    repeat (3) @(negedge clk);
    check64("R1", "prod_q", prod_q, 64'd0);
    check64("R1", "acc_q", acc_q, 64'd0);
    check64("R1", "acc_carry", 64'(acc_carry), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: small directed products
    step(1, 0, 32'd3, 32'd5);
    step(1, 0, 32'd100, 32'd200);
    step(0, 0, 32'hDEAD, 32'hBEEF);             // R7 hold
    step(1, 0, 32'h0001_0000, 32'h0001_0000);
    // R2: all-ones product 0xFFFFFFFE00000001
    step(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R6 seed
    check64("R2", "all-ones product", prod_q, 64'hFFFF_FFFE_0000_0001);
    // R4: repeated all-ones products force wraparound
    for (int i = 0; i < 4; i++) step(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    checks++;
    if (wraps_seen == 0) begin
      failures++;
      $display("FAIL R4 wrap count actual=%0d expected=>0", wraps_seen);
    end
    // R6 right after a wrap: carry must drop, old total discarded
    step(1, 1, 32'd2, 32'd21);
    check64("R6", "seed after wrap", acc_q, 64'd42);
    step(0, 0, 32'd0, 32'd0);                   // R7
    step(0, 1, 32'h1234, 32'h5678);             // R5 clear alone
    check64("R5", "prod held over clear", prod_q, 64'd42);
    step(1, 0, 32'd0, 32'hFFFF_FFFF);           // zero operand

    // Random stream with clears, seeds, idles and all-ones bursts
    for (int n = 0; n < 2000; n++) begin
      int r;
      bit v, c;
      logic [31:0] a, b;
      r = $urandom_range(0, 99);
      v = (r < 75);
      c = (r >= 65 && r < 80) || (r >= 95);
      if ($urandom_range(0, 5) == 0) begin
        a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
      end else begin
        a = $urandom; b = $urandom;
      end
      step(v, c, a, b);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule